// File: doc/BRIEF.md
# Length-Steered Serial Register Port

This block is a three-wire serial slave that writes one of three parallel registers without any address field in the bit stream. A host pulls the active-low enable low, clocks a word in most significant bit first, and releases the enable. The number of serial clock rising edges seen during that window is the only thing that selects the destination. Eight edges write the configuration register. Sixteen write the feedback divider value and also fire a jam-load strobe for both divide counters. Fifteen or twenty-four write the reference divider value. A count from nine to thirteen is a soft reset pattern. Any other count leaves all registers alone.

The serial clock and enable arrive already resampled into the system clock domain. The block finds their edges internally, so every action lands on a system clock edge. The serial output returns the stream delayed by the depth of the shift chain. This lets several ports be chained, where a long transfer walks through one port into the next. The output enable for the data pin is a separate port, so the tri-state buffer sits at the chip pad.

Top module: `lsr_port`

## Requirements
- R1: Serial data is sampled on each rising edge of `ser_clk` while `ser_en_n` is low, and enters most significant bit first: the last bit clocked becomes bit 0 of the written register.
- R2: A transfer of exactly 8 rising edges writes its 8 bits to `cfg_val` when `ser_en_n` rises, and pulses `cfg_load` for one cycle.
- R3: A transfer of exactly 16 rising edges writes `ndiv` and pulses `n_load` and `jam_load` together for one cycle. `jam_load` never pulses otherwise.
- R4: A transfer of 15 or 24 rising edges writes the last 15 bits clocked to `rdiv` and pulses `r_load`. In a 24-bit transfer the first 9 bits are discarded.
- R5: A transfer of 9 to 13 rising edges pulses `reset_req` and returns the registers to their reset values: `cfg_val` = 8'h10, `ndiv` = 0, `rdiv` = 0. These are also the values after `rst_n`.
- R6: A transfer of any other length, including lengths above 32, changes no register and pulses no strobe.
- R7: Register outputs never change while `ser_en_n` is low. They change only in the cycle after `ser_en_n` rises.
- R8: `ser_dout_oe` is low while `ser_en_n` is high, and high from the cycle after `ser_en_n` falls until it rises again.
- R9: On each falling edge of `ser_clk` during a transfer, `ser_dout` takes the bit that was clocked in 24 rising edges earlier, or 0 if fewer than 24 bits have been received.
- R10: `ser_clk` edges while `ser_en_n` is high are ignored. The bit count starts from zero in every transfer.
- R11: The four strobes `cfg_load`, `n_load`, `r_load` and `reset_req` are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, resampled to `clk` |
| ser_en_n | input | 1 | Active-low transfer enable, resampled to `clk` |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Delayed serial data out for chaining |
| ser_dout_oe | output | 1 | Drive enable for the serial data out pad |
| cfg_val | output | 8 | Configuration register |
| ndiv | output | 16 | Feedback divider register |
| rdiv | output | 15 | Reference divider register |
| cfg_load | output | 1 | Pulse: configuration written |
| n_load | output | 1 | Pulse: feedback divider written |
| r_load | output | 1 | Pulse: reference divider written |
| jam_load | output | 1 | Pulse: preset both divide counters |
| reset_req | output | 1 | Pulse: reset pattern received |

## Verification
The checks assume that `ser_clk` and `ser_en_n` hold each level for at least two system clocks. They also assume that `ser_en_n` changes only while `ser_clk` is low, and that `ser_din` is stable across each rising edge. The stimulus meets all three conditions. It holds every serial phase for two system clocks, and changes data and enable only with the serial clock low. It also keeps both serial inputs idle during reset. The scoreboard expects a register write only on the enable release that ends a counted transfer. It also checks, on every cycle of a transfer, that the outputs still hold their last committed values.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    // Destination chosen by the bit count of a finished transfer
    typedef enum logic [2:0] {
        CMT_NONE,
        CMT_CFG,
        CMT_NDIV,
        CMT_RDIV,
        CMT_RESET
    } commit_e;

endpackage

// File: rtl/lsr_edge.sv
module lsr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sen_n,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sen_rise,
    output logic sen_active
);

    typedef struct packed {
        logic sclk;
        logic sen_n;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.sclk  = sclk;
        st_d.sen_n = sen_n;
        sclk_rise  = sclk & ~st_q.sclk;
        sclk_fall  = ~sclk & st_q.sclk;
        sen_rise   = sen_n & ~st_q.sen_n;
        sen_active = ~sen_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sclk  <= 1'b0;
            st_q.sen_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lsr_shifter.sv
module lsr_shifter #(
    parameter int unsigned SR_W    = 24,
    parameter int unsigned LOW_W   = 16,
    parameter int unsigned CNT_MAX = 32,
    localparam int unsigned CNT_W  = $clog2(CNT_MAX + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             din,
    output logic [LOW_W-1:0] word_low,
    output logic [CNT_W-1:0] bit_cnt,
    output logic             dout,
    output logic             dout_oe
);

    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(CNT_MAX + 1);

    typedef struct packed {
        logic [SR_W-1:0]  sr;
        logic [CNT_W-1:0] cnt;
        logic             dout;
        logic             oe;
    } shf_st_t;

    shf_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.oe = active;
        if (!active) begin
            st_d.sr   = '0;
            st_d.cnt  = '0;
            st_d.dout = 1'b0;
        end else begin
            if (sclk_rise) begin
                st_d.sr = {st_q.sr[SR_W-2:0], din};
                if (st_q.cnt != CNT_SAT) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            if (sclk_fall) begin
                st_d.dout = st_q.sr[SR_W-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_low = st_q.sr[LOW_W-1:0];
    assign bit_cnt  = st_q.cnt;
    assign dout     = st_q.dout;
    assign dout_oe  = st_q.oe;

endmodule

// File: rtl/lsr_commit.sv
module lsr_commit
    import lsr_pkg::*;
#(
    parameter int unsigned CFG_W    = 8,
    parameter int unsigned N_W      = 16,
    parameter int unsigned R_W      = 15,
    parameter int unsigned R_LONG   = 24,
    parameter int unsigned RST_LO   = 9,
    parameter int unsigned RST_HI   = 13,
    parameter int unsigned CNT_MAX  = 32,
    parameter logic [CFG_W-1:0] CFG_INIT = 8'h10,
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [N_W-1:0]   word_low,
    input  logic [CNT_W-1:0] bit_cnt,
    output logic [CFG_W-1:0] cfg_val,
    output logic [N_W-1:0]   ndiv,
    output logic [R_W-1:0]   rdiv,
    output logic             cfg_load,
    output logic             n_load,
    output logic             r_load,
    output logic             jam_load,
    output logic             reset_req
);

    localparam logic [CNT_W-1:0] LEN_CFG  = CNT_W'(CFG_W);
    localparam logic [CNT_W-1:0] LEN_N    = CNT_W'(N_W);
    localparam logic [CNT_W-1:0] LEN_RS   = CNT_W'(R_W);
    localparam logic [CNT_W-1:0] LEN_RL   = CNT_W'(R_LONG);
    localparam logic [CNT_W-1:0] LEN_RSLO = CNT_W'(RST_LO);
    localparam logic [CNT_W-1:0] LEN_RSHI = CNT_W'(RST_HI);

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [N_W-1:0]   ndiv;
        logic [R_W-1:0]   rdiv;
        logic             cfg_ld;
        logic             n_ld;
        logic             r_ld;
        logic             jam;
        logic             rst_req;
    } cmt_st_t;

    cmt_st_t st_d, st_q;
    commit_e kind;

    always_comb begin
        if (bit_cnt == LEN_CFG) begin
            kind = CMT_CFG;
        end else if (bit_cnt == LEN_N) begin
            kind = CMT_NDIV;
        end else if (bit_cnt == LEN_RS || bit_cnt == LEN_RL) begin
            kind = CMT_RDIV;
        end else if (bit_cnt >= LEN_RSLO && bit_cnt <= LEN_RSHI) begin
            kind = CMT_RESET;
        end else begin
            kind = CMT_NONE;
        end
    end

    always_comb begin
        st_d         = st_q;
        st_d.cfg_ld  = 1'b0;
        st_d.n_ld    = 1'b0;
        st_d.r_ld    = 1'b0;
        st_d.jam     = 1'b0;
        st_d.rst_req = 1'b0;
        if (commit) begin
            unique case (kind)
                CMT_CFG: begin
                    st_d.cfg    = word_low[CFG_W-1:0];
                    st_d.cfg_ld = 1'b1;
                end
                CMT_NDIV: begin
                    st_d.ndiv = word_low;
                    st_d.n_ld = 1'b1;
                    st_d.jam  = 1'b1;
                end
                CMT_RDIV: begin
                    st_d.rdiv = word_low[R_W-1:0];
                    st_d.r_ld = 1'b1;
                end
                CMT_RESET: begin
                    st_d.cfg     = CFG_INIT;
                    st_d.ndiv    = '0;
                    st_d.rdiv    = '0;
                    st_d.rst_req = 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cfg <= CFG_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_val   = st_q.cfg;
    assign ndiv      = st_q.ndiv;
    assign rdiv      = st_q.rdiv;
    assign cfg_load  = st_q.cfg_ld;
    assign n_load    = st_q.n_ld;
    assign r_load    = st_q.r_ld;
    assign jam_load  = st_q.jam;
    assign reset_req = st_q.rst_req;

endmodule

// File: rtl/lsr_port.sv
module lsr_port #(
    parameter int unsigned CFG_W   = 8,
    parameter int unsigned N_W     = 16,
    parameter int unsigned R_W     = 15,
    parameter int unsigned SR_W    = 24,
    parameter int unsigned RST_LO  = 9,
    parameter int unsigned RST_HI  = 13,
    parameter int unsigned CNT_MAX = 32,
    parameter logic [CFG_W-1:0] CFG_INIT = 8'h10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_en_n,
    input  logic             ser_din,
    output logic             ser_dout,
    output logic             ser_dout_oe,
    output logic [CFG_W-1:0] cfg_val,
    output logic [N_W-1:0]   ndiv,
    output logic [R_W-1:0]   rdiv,
    output logic             cfg_load,
    output logic             n_load,
    output logic             r_load,
    output logic             jam_load,
    output logic             reset_req
);

    localparam int unsigned CNT_W = $clog2(CNT_MAX + 2);

    logic             sclk_rise;
    logic             sclk_fall;
    logic             sen_rise;
    logic             sen_active;
    logic [N_W-1:0]   word_low;
    logic [CNT_W-1:0] bit_cnt;

    lsr_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (ser_clk),
        .sen_n      (ser_en_n),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .sen_rise   (sen_rise),
        .sen_active (sen_active)
    );

    lsr_shifter #(
        .SR_W    (SR_W),
        .LOW_W   (N_W),
        .CNT_MAX (CNT_MAX)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (sen_active),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din       (ser_din),
        .word_low  (word_low),
        .bit_cnt   (bit_cnt),
        .dout      (ser_dout),
        .dout_oe   (ser_dout_oe)
    );

    lsr_commit #(
        .CFG_W    (CFG_W),
        .N_W      (N_W),
        .R_W      (R_W),
        .R_LONG   (SR_W),
        .RST_LO   (RST_LO),
        .RST_HI   (RST_HI),
        .CNT_MAX  (CNT_MAX),
        .CFG_INIT (CFG_INIT)
    ) u_commit (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (sen_rise),
        .word_low  (word_low),
        .bit_cnt   (bit_cnt),
        .cfg_val   (cfg_val),
        .ndiv      (ndiv),
        .rdiv      (rdiv),
        .cfg_load  (cfg_load),
        .n_load    (n_load),
        .r_load    (r_load),
        .jam_load  (jam_load),
        .reset_req (reset_req)
    );

endmodule

// File: rtl/lsr_port_chk.sv
module lsr_port_chk #(
    parameter int unsigned CFG_W = 8,
    parameter int unsigned N_W   = 16,
    parameter int unsigned R_W   = 15,
    parameter logic [CFG_W-1:0] CFG_INIT = 8'h10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_en_n,
    input logic             ser_dout_oe,
    input logic [CFG_W-1:0] cfg_val,
    input logic [N_W-1:0]   ndiv,
    input logic [R_W-1:0]   rdiv,
    input logic             cfg_load,
    input logic             n_load,
    input logic             r_load,
    input logic             jam_load,
    input logic             reset_req
);

    logic any_strobe;
    assign any_strobe = cfg_load | n_load | r_load | reset_req;

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_load, n_load, r_load, reset_req})); // R11

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |=> !any_strobe); // R11

    AST_JAM_WITH_N: assert property (@(posedge clk) disable iff (!rst_n)
        jam_load == n_load); // R3

    AST_RESET_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (cfg_val == CFG_INIT && ndiv == '0 && rdiv == '0)); // R5

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_load && !reset_req) |-> $stable(cfg_val)); // R7

    AST_NDIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!n_load && !reset_req) |-> $stable(ndiv)); // R7

    AST_RDIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_load && !reset_req) |-> $stable(rdiv)); // R7

    AST_STROBE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |-> ($past(ser_en_n) && !$past(ser_en_n, 2))); // R7

    AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ser_en_n) |-> !ser_dout_oe); // R8

endmodule

bind lsr_port lsr_port_chk #(
    .CFG_W    (CFG_W),
    .N_W      (N_W),
    .R_W      (R_W),
    .CFG_INIT (CFG_INIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_en_n    (ser_en_n),
    .ser_dout_oe (ser_dout_oe),
    .cfg_val     (cfg_val),
    .ndiv        (ndiv),
    .rdiv        (rdiv),
    .cfg_load    (cfg_load),
    .n_load      (n_load),
    .r_load      (r_load),
    .jam_load    (jam_load),
    .reset_req   (reset_req)
);

// File: tb/tb_lsr_port.sv
module tb_lsr_port;

    localparam logic [7:0] CFG_RST = 8'h10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ser_clk;
    logic        ser_en_n;
    logic        ser_din;
    logic        ser_dout;
    logic        ser_dout_oe;
    logic [7:0]  cfg_val;
    logic [15:0] ndiv;
    logic [14:0] rdiv;
    logic        cfg_load, n_load, r_load, jam_load, reset_req;

    always #10 clk = ~clk;

    lsr_port dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_en_n(ser_en_n),
        .ser_din(ser_din), .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe),
        .cfg_val(cfg_val), .ndiv(ndiv), .rdiv(rdiv), .cfg_load(cfg_load),
        .n_load(n_load), .r_load(r_load), .jam_load(jam_load),
        .reset_req(reset_req)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // kind: 0 cfg, 1 ndiv, 2 rdiv, 3 reset
    typedef struct {
        int          kind;
        logic [23:0] val;
    } exp_t;

    exp_t sbq[$];

    logic [7:0]  mdl_cfg = CFG_RST;
    logic [15:0] mdl_n   = '0;
    logic [14:0] mdl_r   = '0;

    // Monitor: pops one expected item for each strobe
    exp_t got;
    int   act_kind;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cfg_load | n_load | r_load | reset_req) begin
                chk($countones({cfg_load, n_load, r_load, reset_req}) == 1, "R11",
                    {28'd0, cfg_load, n_load, r_load, reset_req}, 32'd1);
                act_kind = cfg_load ? 0 : n_load ? 1 : r_load ? 2 : 3;
                if (sbq.size() == 0) begin
                    chk(1'b0, "R6 unexpected strobe", act_kind, 32'hFFFF);
                end else begin
                    got = sbq.pop_front();
                    chk(act_kind == got.kind, "R2/R3/R4/R5 destination", act_kind, got.kind);
                    case (got.kind)
                        0: begin
                            chk(cfg_val == got.val[7:0], "R2 cfg value", cfg_val, got.val);
                            mdl_cfg = got.val[7:0];
                        end
                        1: begin
                            chk(ndiv == got.val[15:0], "R3 ndiv value", ndiv, got.val);
                            mdl_n = got.val[15:0];
                        end
                        2: begin
                            chk(rdiv == got.val[14:0], "R4 rdiv value", rdiv, got.val);
                            mdl_r = got.val[14:0];
                        end
                        default: begin
                            mdl_cfg = CFG_RST;
                            mdl_n   = '0;
                            mdl_r   = '0;
                            chk({cfg_val, ndiv, rdiv} == {CFG_RST, 16'd0, 15'd0}, "R5 restore",
                                {1'b0, cfg_val, ndiv[7:0], rdiv[14:0]}, {1'b0, CFG_RST, 23'd0});
                        end
                    endcase
                end
                chk(jam_load == n_load, "R3 jam strobe", jam_load, n_load);
            end else if (!ser_en_n) begin
                chk({cfg_val, ndiv, rdiv} == {mdl_cfg, mdl_n, mdl_r}, "R7 held while shifting",
                    {1'b0, cfg_val, ndiv[7:0], rdiv}, {1'b0, mdl_cfg, mdl_n[7:0], mdl_r});
            end
        end
    end

    task automatic wrap_up;
        chk(sbq.size() == 0, "R2/R3/R4/R5 missing strobe", sbq.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // Serial transfer; casc enables per-fall output checking
    task automatic xfer(input logic [63:0] w, input int len, input bit casc);
        logic bits [64];
        ser_en_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(ser_dout_oe == 1'b1, "R8 oe during transfer", ser_dout_oe, 1);
        for (int k = 0; k < len; k++) begin
            bits[k] = w[len-1-k];
            ser_clk = 1'b0;
            ser_din = bits[k];
            @(negedge clk);
            if (casc && k >= 1)
                chk(ser_dout == ((k >= 24) ? bits[k-24] : 1'b0), "R9 chained output",
                    ser_dout, (k >= 24) ? bits[k-24] : 1'b0);
            @(negedge clk);
            ser_clk = 1'b1;
            repeat (2) @(negedge clk);
        end
        ser_clk = 1'b0;
        @(negedge clk);
        if (casc)
            chk(ser_dout == ((len >= 24) ? bits[len-24] : 1'b0), "R9 chained output",
                ser_dout, (len >= 24) ? bits[len-24] : 1'b0);
        @(negedge clk);
        ser_en_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(ser_dout_oe == 1'b0, "R8 oe idle", ser_dout_oe, 0);
    endtask

    // Driver: enqueue what the requirements predict, then shift
    task automatic send(input logic [63:0] w, input int len, input bit casc);
        exp_t e;
        e.val = '0;
        e.kind = -1;
        if (len == 8) begin
            e.kind = 0; e.val = {16'd0, w[7:0]};
        end else if (len == 16) begin
            e.kind = 1; e.val = {8'd0, w[15:0]};
        end else if (len == 15 || len == 24) begin
            e.kind = 2; e.val = {9'd0, w[14:0]};
        end else if (len >= 9 && len <= 13) begin
            e.kind = 3;
        end
        if (e.kind >= 0) sbq.push_back(e);
        xfer(w, len, casc);
    endtask

    task automatic expect_unchanged(input string req);
        chk(cfg_val == mdl_cfg, req, cfg_val, mdl_cfg);
        chk(ndiv == mdl_n, req, ndiv, mdl_n);
        chk(rdiv == mdl_r, req, rdiv, mdl_r);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        wrap_up();
    end

    initial begin
        rst_n = 1'b0; ser_clk = 1'b0; ser_en_n = 1'b1; ser_din = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R5 values, R8 idle pad)
        chk(cfg_val == CFG_RST, "R5 reset cfg", cfg_val, CFG_RST);
        chk(ndiv == 0 && rdiv == 0, "R5 reset dividers", {ndiv, 1'b0, rdiv}, 0);
        chk(ser_dout_oe == 0 && ser_dout == 0, "R8 reset pad", {ser_dout_oe, ser_dout}, 0);
        chk(!(cfg_load | n_load | r_load | jam_load | reset_req), "R11 reset strobes", 1, 0);

        // R1 R2: bit order and configuration writes
        send(64'hA5, 8, 0);
        send(64'h3C, 8, 0);
        // R3: feedback divider with jam strobe
        send(64'hBEEF, 16, 0);
        send(64'h0028, 16, 0);
        // R4: both reference divider lengths
        send(64'h5A5A, 15, 0);
        send(64'hFF9234, 24, 0);
        chk(rdiv == 15'h1234, "R4 long access keeps low bits", rdiv, 15'h1234);

        // R10: clock activity with enable high is ignored
        repeat (5) begin
            ser_clk = 1'b1; repeat (2) @(negedge clk);
            ser_clk = 1'b0; repeat (2) @(negedge clk);
        end
        chk(ser_dout_oe == 0, "R10 idle clocking", ser_dout_oe, 0);
        expect_unchanged("R10 idle clocking");
        send(64'h81, 8, 0);
        chk(cfg_val == 8'h81, "R10 count restarts", cfg_val, 8'h81);

        // R6: lengths that select nothing
        send(64'h7F, 7, 0);
        expect_unchanged("R6 length 7");
        send(64'h3FFF, 14, 0);
        expect_unchanged("R6 length 14");
        send(64'h1ABCD, 17, 0);
        expect_unchanged("R6 length 17");
        send(64'h7FFFFF, 23, 0);
        expect_unchanged("R6 length 23");
        send(64'h1555555, 25, 0);
        expect_unchanged("R6 length 25");
        send(64'hDEADBEEF, 32, 0);
        expect_unchanged("R6 length 32");

        // R9: long chained transfer, R6 for lengths above 32
        send(64'hC3_9A5E_71B2, 40, 1);
        expect_unchanged("R6 length 40");

        // R5: reset pattern boundaries
        send(64'h1FF, 9, 0);
        chk(cfg_val == CFG_RST && ndiv == 0, "R5 length 9", {cfg_val, ndiv}, {CFG_RST, 16'd0});
        send(64'h4321, 16, 0);
        send(64'h07C, 8, 0);
        send(64'h7FF, 11, 0);
        send(64'h2222, 15, 0);
        send(64'h1ACE, 13, 0);
        chk(rdiv == 0 && cfg_val == CFG_RST, "R5 length 13", {cfg_val, rdiv}, {CFG_RST, 15'd0});

        // R1: single set bit at each end of the word
        send(64'h8000, 16, 0);
        send(64'h0001, 16, 0);

        repeat (4) @(negedge clk);
        wrap_up();
    end

endmodule